// File: doc/BRIEF.md
# ALU Operation Code Decoder

This block turns the decode-stage view of an integer instruction into the 5-bit operation code that selects the ALU function. It takes a 3-bit instruction-class code from the main decoder together with the raw funct3 and funct7 fields. Register-register and register-immediate arithmetic, the three shift types and the multiply/divide group each get their own code. Loads, stores, conditional branches and jumps get fixed codes.

The whole 7-bit funct7 field is inspected, not a single flag bit. That is what lets subtract and arithmetic right shift (register and immediate forms) get codes of 8 and above, and what moves the multiply/divide group to codes 14 to 21. The block is purely combinational. A new class/funct combination shows up on the output in the same cycle, with no register in between, so it can sit between the decode logic and the decode/execute pipeline register. No data stream passes through it, so it has no valid/ready handshake. Every pin is a plain level.

Top module: `alu_op_decoder`

## Requirements
- R1: Class code 0 (register-register) with funct7 other than 0000001 gives code {0, funct7[5], funct3}, so ADD = 0, SUB = 8, SRL = 5, SRA = 13.
- R2: Class code 0 with funct7 equal to 0000001 gives code 14 + funct3 (MUL 14, MULH 15, MULHSU 16, MULHU 17, DIV 18, DIVU 19, REM 20, REMU 21).
- R3: Class code 1 (register-immediate) with funct3 other than 5 gives code {00, funct3}, and funct7 is ignored, so ADDI with funct7[5] set still gives 0 and never 8.
- R4: Class code 1 with funct3 = 5 gives 13 when funct7[5] is 1 (SRAI) and 5 when it is 0 (SRLI).
- R5: Class codes 2 (load) and 3 (store) give 0 (the add code) for every funct3 and funct7.
- R6: Class code 4 (conditional branch) gives 22 for every funct3 and funct7.
- R7: Class code 5 (jump) gives 31 for every funct3 and funct7.
- R8: Class codes 6 and 7 are unassigned and give 0 for every funct3 and funct7.
- R9: The output follows the inputs combinationally, with no register between them, so a change on the inputs shows up before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 3 | Instruction class from the main decoder (0 reg-reg, 1 reg-imm, 2 load, 3 store, 4 branch, 5 jump, 6-7 unassigned) |
| funct3_i | input | 3 | Instruction funct3 field |
| funct7_i | input | 7 | Instruction funct7 field, all seven bits |
| alu_op_o | output | 5 | ALU operation code |

## Verification
The bench sweeps every class, every funct3 value and all 128 funct7 values. Each combination is compared with a behavioural table. The full funct7 sweep tells the multiply/divide pattern 0000001 apart from its near neighbours 0000000, 0000011 and 0100001. It also shows that funct7 bits other than bit 5 move the register-register code only in the multiply/divide case. For the immediate class, the sweep shows that only the right-shift funct3 reacts to funct7[5]. For the fixed classes, it shows that funct fields have no effect at all. Inputs change right after a clock edge and the output is read at the following falling edge, so a registered output would be caught.

// File: rtl/alu_op_pkg.sv
package alu_op_pkg;

  localparam int unsigned CLS_W = 3;
  localparam int unsigned F3_W  = 3;
  localparam int unsigned F7_W  = 7;
  localparam int unsigned OP_W  = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_REG    = 3'd0,
    CLS_IMM    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_JUMP   = 3'd5,
    CLS_RSV6   = 3'd6,
    CLS_RSV7   = 3'd7
  } insn_cls_e;

  // funct7 value marking the multiply/divide group
  localparam logic [F7_W-1:0] F7_MULDIV = 7'b0000001;
  // funct7 bit separating sub/arith-shift from add/logical-shift
  localparam int unsigned     F7_ALT_BIT = 5;
  // funct3 value of the right-shift pair
  localparam logic [F3_W-1:0] F3_SHR = 3'd5;

  localparam logic [OP_W-1:0] OP_ADD    = 5'd0;
  localparam logic [OP_W-1:0] OP_SRA    = 5'd13;
  localparam logic [OP_W-1:0] OP_MULDIV = 5'd14;
  localparam logic [OP_W-1:0] OP_BRANCH = 5'd22;
  localparam logic [OP_W-1:0] OP_JUMP   = 5'd31;

endpackage

// File: rtl/alu_rr_dec.sv
module alu_rr_dec
  import alu_op_pkg::*;
#(
  parameter logic [OP_W-1:0] MULDIV_BASE = OP_MULDIV
) (
  input  logic [F3_W-1:0] funct3_i,
  input  logic [F7_W-1:0] funct7_i,
  output logic [OP_W-1:0] op_o
);

  localparam int unsigned PAD_W = OP_W - F3_W - 1;

  logic is_muldiv;
  logic [OP_W-1:0] base_op;
  logic [OP_W-1:0] md_op;

  assign is_muldiv = (funct7_i == F7_MULDIV);
  assign base_op   = {{PAD_W{1'b0}}, funct7_i[F7_ALT_BIT], funct3_i};
  assign md_op     = MULDIV_BASE + {{(OP_W-F3_W){1'b0}}, funct3_i};
  assign op_o      = is_muldiv ? md_op : base_op;

  always_comb begin
    // R2: the multiply/divide group lands in 14..21
    if (funct7_i == 7'b0000001)
      a_r2_muldiv_range: assert (op_o >= 5'd14 && op_o <= 5'd21);
    // R1: plain funct7 of zero never yields a code above 7
    if (funct7_i == 7'b0000000)
      a_r1_base_low: assert (op_o < 5'd8);
  end

endmodule

// File: rtl/alu_ri_dec.sv
module alu_ri_dec
  import alu_op_pkg::*;
(
  input  logic [F3_W-1:0] funct3_i,
  input  logic [F7_W-1:0] funct7_i,
  output logic [OP_W-1:0] op_o
);

  logic arith_shr;

  assign arith_shr = (funct3_i == F3_SHR) && funct7_i[F7_ALT_BIT];
  assign op_o      = arith_shr ? OP_SRA : {{(OP_W-F3_W){1'b0}}, funct3_i};

  always_comb begin
    // R3: immediate forms other than right shift stay below 8
    if (funct3_i != 3'd5)
      a_r3_imm_low: assert (op_o < 5'd8);
    // R4: right-shift immediate is either 5 or 13
    if (funct3_i == 3'd5)
      a_r4_shr_pair: assert (op_o == 5'd5 || op_o == 5'd13);
  end

endmodule

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_op_pkg::*;
(
  input  logic [2:0] cls_i,
  input  logic [2:0] funct3_i,
  input  logic [6:0] funct7_i,
  output logic [4:0] alu_op_o
);

  logic [OP_W-1:0] rr_op;
  logic [OP_W-1:0] ri_op;
  insn_cls_e       cls;

  assign cls = insn_cls_e'(cls_i);

  alu_rr_dec #(.MULDIV_BASE(OP_MULDIV)) u_rr (
    .funct3_i (funct3_i),
    .funct7_i (funct7_i),
    .op_o     (rr_op)
  );

  alu_ri_dec u_ri (
    .funct3_i (funct3_i),
    .funct7_i (funct7_i),
    .op_o     (ri_op)
  );

  always_comb begin
    unique case (cls)
      CLS_REG:             alu_op_o = rr_op;
      CLS_IMM:             alu_op_o = ri_op;
      CLS_LOAD, CLS_STORE: alu_op_o = OP_ADD;
      CLS_BRANCH:          alu_op_o = OP_BRANCH;
      CLS_JUMP:            alu_op_o = OP_JUMP;
      default:             alu_op_o = OP_ADD;
    endcase
  end

  always_comb begin
    // R5: memory classes use the add code
    if (cls_i == 3'd2 || cls_i == 3'd3)
      a_r5_mem_add: assert (alu_op_o == 5'd0);
    // R6: branch code is fixed
    if (cls_i == 3'd4)
      a_r6_branch_fixed: assert (alu_op_o == 5'd22);
    // R7: jump code is fixed
    if (cls_i == 3'd5)
      a_r7_jump_fixed: assert (alu_op_o == 5'd31);
    // R8: unassigned classes give zero
    if (cls_i[2:1] == 2'b11)
      a_r8_rsv_zero: assert (alu_op_o == 5'd0);
  end

endmodule

// File: tb/alu_op_decoder_tb_top.sv
module alu_op_decoder_tb_top;

  localparam time CLK_HALF = 5ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cls_i = '0;
  logic [2:0] funct3_i = '0;
  logic [6:0] funct7_i = '0;
  logic [4:0] alu_op_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  alu_op_decoder dut_i (
    .cls_i    (cls_i),
    .funct3_i (funct3_i),
    .funct7_i (funct7_i),
    .alu_op_o (alu_op_o)
  );

  // Behavioural expectation, written from the requirement list
  function automatic int expect_op(int c, int f3, int f7);
    case (c)
      0: begin
        if (f7 == 1) return 14 + f3;               // R2
        if ((f7 / 32) % 2 == 1) return 8 + f3;     // R1 alt half
        return f3;                                 // R1
      end
      1: begin
        if (f3 == 5) return ((f7 / 32) % 2 == 1) ? 13 : 5; // R4
        return f3;                                 // R3
      end
      2, 3: return 0;                              // R5
      4:    return 22;                             // R6
      5:    return 31;                             // R7
      default: return 0;                           // R8
    endcase
  endfunction

  function automatic string req_of(int c, int f3, int f7);
    case (c)
      0: return (f7 == 1) ? "R2" : "R1";
      1: return (f3 == 5) ? "R4" : "R3";
      2, 3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int exp);
    n_cmp++;
    if (int'(alu_op_o) != exp) begin
      n_bad++;
      $display("FAIL %s cls=%0d f3=%0d f7=%0h actual=%0d expected=%0d",
               req, cls_i, funct3_i, funct7_i, alu_op_o, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all-zero inputs are a register-register ADD (R1)
    check("R1", 0);
    rst = 1'b0;
    for (int c = 0; c < 8; c++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        for (int f7 = 0; f7 < 128; f7++) begin
          @(posedge clk);
          cls_i    = 3'(c);
          funct3_i = 3'(f3);
          funct7_i = 7'(f7);
          // R9: read before the next rising edge
          @(negedge clk);
          check(req_of(c, f3, f7), expect_op(c, f3, f7));
        end
      end
    end
    // R9: input change with no clock edge in between
    @(posedge clk);
    cls_i = 3'd5; funct3_i = 3'd0; funct7_i = 7'd0;
    #1ns;
    cls_i = 3'd4;
    #1ns;
    check("R9", 22);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule